// File: doc/BRIEF.md
# Nonvolatile Trim Programming Sequencer

This block is the host-side controller for a serially programmed trim device that holds an 11-bit control word in nonvolatile cells. The block drives three lines: a serial data line, a serial clock and an enable for the external high-voltage programming pulse. It reads a comparator input that reflects the level on the programming-voltage line. Given a target word and a start strike, it first reads back every stored cell. To read a cell, it shifts a select word in which only that cell's position is low, holds data and clock high, and samples the comparator. It then turns the target into the stored polarity and works out which cells must change. It programs each of those cells in its own timed cycle, and finishes with a second full read-back that decides pass or fail.

An erase request replaces the compare-and-write phase with one pulse carrying an all-ones select word, followed by the same verify read-back. All timing comes from the system clock. A clock-frequency parameter converts the serial clock rate and the microsecond intervals into tick counts. The high-voltage driver itself lies outside this block.

Top module: `trim_prog_seq`

## Requirements
- R1: While and right after reset, ser_clk, ser_data, pv_en, busy, done and pass are 0 and wr_count is 0.
- R2: A frame sends W bits with bit0 first. Each bit cell holds ser_data for HALF_TK ticks with ser_clk low, then HALF_TK ticks with ser_clk high, so the device captures the bit on the rising edge. HALF_TK = CLK_HZ/(2*SCLK_HZ).
- R3: A read of position i shifts a word with only bit i at 0. After the last high half, both ser_data and ser_clk are held high for SETTLE_TK ticks. sense_in is then sampled, and 1 means the stored cell is 1. After that both lines drop low.
- R4: The target is inverted to give the wanted stored image. The positions 1..W-1 where the read-back differs from that image are programmed. Position 0 (check cell, mask bit 0 of CHECK_MASK) is never compared, written or verified.
- R5: Each program cycle shifts a word with exactly one position at 0, the others at 1. Positions are handled in ascending order. wr_count counts these cycles.
- R6: pv_en stays high for exactly PULSE_TK ticks. Before and after the pulse, ser_clk stays low for at least GAP_TK ticks.
- R7: An erase (erase_req=1 at start) shifts an all-ones word and gives one pulse with wr_count left at 0. Its verify expects positions 1..W-1 to read 1.
- R8: After the writes, a full read-back sets pass=1 exactly when all compared positions match. done is a one-cycle pulse, busy falls in the cycle after done, and pass and wr_count hold until the next start.
- R9: A start strike while busy is ignored. The running sequence, its shifted words and its results are unchanged.
- R10: For a target of 00000010100 on an erased device, exactly two program cycles occur: position 2 (word 11111111011), then position 4 (word 11111101111).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sequence (taken only when idle) |
| erase_req | input | 1 | Sampled with start: 1 = erase sequence, 0 = program sequence |
| target | input | W | Wanted control word, active-high polarity |
| sense_in | input | 1 | Comparator result of the programming-voltage line |
| ser_clk | output | 1 | Serial clock to the device |
| ser_data | output | 1 | Serial data to the device |
| pv_en | output | 1 | Enable of the external programming-pulse driver |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence strike |
| pass | output | 1 | Verify result of the last sequence |
| wr_count | output | $clog2(W+1) | Number of program cycles in the last sequence |

## Verification
A start strike can land in the same cycle as a running sequence. The strike is issued well into a program sequence, with erase_req set and an inverted target, so it would change both the next frame and the pulse word if it were accepted. The scoreboard holds the exact ordered list of pulse words and the final pass and count that the first request alone should produce. Any extra erase word, changed order or different count shows up as a mismatch. A bench-side device model keeps the cell contents, so later sequences also expose any stray pulse through their own read-back.

// File: rtl/trim_prog_pkg.sv
package trim_prog_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RD_SHIFT,
    ST_RD_SETTLE,
    ST_EVAL,
    ST_PICK,
    ST_WR_SHIFT,
    ST_WR_GAP1,
    ST_WR_PULSE,
    ST_WR_GAP2,
    ST_DONE
  } seq_state_t;

  typedef enum logic [1:0] {
    SH_IDLE,
    SH_LOW,
    SH_HIGH
  } sh_phase_t;

endpackage

// File: rtl/trim_tick_timer.sv
module trim_tick_timer #(
  parameter int unsigned TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - TW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/trim_word_shifter.sv
module trim_word_shifter
  import trim_prog_pkg::*;
#(
  parameter int unsigned W       = 11,
  parameter int unsigned HALF_TK = 500
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] word_in,
  output logic         ser_clk,
  output logic         ser_data,
  output logic         frame_done
);

  localparam int unsigned IW = $clog2(W);
  localparam int unsigned TW = $clog2(HALF_TK + 1);

  sh_phase_t     phase_q, phase_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [W-1:0]  word_q, word_d;
  logic          tm_load, tm_exp;

  trim_tick_timer #(.TW(TW)) u_half (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tm_load),
    .load_val (TW'(HALF_TK - 1)),
    .expired  (tm_exp)
  );

  always_comb begin
    phase_d    = phase_q;
    idx_d      = idx_q;
    word_d     = word_q;
    tm_load    = 1'b0;
    frame_done = 1'b0;
    unique case (phase_q)
      SH_IDLE: begin
        if (start) begin
          word_d  = word_in;
          idx_d   = '0;
          phase_d = SH_LOW;
          tm_load = 1'b1;
        end
      end
      SH_LOW: begin
        if (tm_exp) begin
          phase_d = SH_HIGH;
          tm_load = 1'b1;
        end
      end
      SH_HIGH: begin
        if (tm_exp) begin
          if (idx_q == IW'(W - 1)) begin
            phase_d    = SH_IDLE;
            frame_done = 1'b1;
          end else begin
            idx_d   = idx_q + IW'(1);
            phase_d = SH_LOW;
            tm_load = 1'b1;
          end
        end
      end
      default: phase_d = SH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= SH_IDLE;
      idx_q   <= '0;
      word_q  <= '0;
    end else begin
      phase_q <= phase_d;
      idx_q   <= idx_d;
      word_q  <= word_d;
    end
  end

  assign ser_clk  = (phase_q == SH_HIGH);
  assign ser_data = (phase_q != SH_IDLE) && word_q[idx_q];

endmodule

// File: rtl/trim_prog_ctrl.sv
module trim_prog_ctrl
  import trim_prog_pkg::*;
#(
  parameter int unsigned W          = 11,
  parameter logic [W-1:0] CHECK_MASK = {{(W-1){1'b1}}, 1'b0},
  parameter int unsigned GAP_TK     = 400,
  parameter int unsigned PULSE_TK   = 1000000,
  parameter int unsigned SETTLE_TK  = 200
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   erase_req,
  input  logic [W-1:0]           target,
  input  logic                   sense_in,
  input  logic                   frame_done,
  output logic                   sh_start,
  output logic [W-1:0]           sh_word,
  output logic                   hold_high,
  output logic                   pv_en,
  output logic                   busy,
  output logic                   done,
  output logic                   pass,
  output logic [$clog2(W+1)-1:0] wr_count
);

  localparam int unsigned IW = $clog2(W);
  localparam int unsigned CW = $clog2(W + 1);
  localparam int unsigned TW = $clog2(PULSE_TK + GAP_TK + SETTLE_TK + 1);

  seq_state_t    state_q, state_d;
  logic          erase_q, erase_d;
  logic          verify_q, verify_d;
  logic [IW-1:0] rd_idx_q, rd_idx_d;
  logic [W-1:0]  image_q, image_d;
  logic [W-1:0]  want_q, want_d;
  logic [W-1:0]  todo_q, todo_d;
  logic [CW-1:0] wr_cnt_q, wr_cnt_d;
  logic          pass_q, pass_d;
  logic          tm_load, tm_exp;
  logic [TW-1:0] tm_val;
  logic [IW-1:0] pick_idx;

  function automatic logic [W-1:0] sel_low(input logic [IW-1:0] pos);
    sel_low      = '1;
    sel_low[pos] = 1'b0;
  endfunction

  function automatic logic [IW-1:0] lowest_set(input logic [W-1:0] v);
    lowest_set = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (v[i]) lowest_set = IW'(i);
    end
  endfunction

  trim_tick_timer #(.TW(TW)) u_wait (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tm_load),
    .load_val (tm_val),
    .expired  (tm_exp)
  );

  assign pick_idx = lowest_set(todo_q);

  always_comb begin
    state_d  = state_q;
    erase_d  = erase_q;
    verify_d = verify_q;
    rd_idx_d = rd_idx_q;
    image_d  = image_q;
    want_d   = want_q;
    todo_d   = todo_q;
    wr_cnt_d = wr_cnt_q;
    pass_d   = pass_q;
    sh_start = 1'b0;
    sh_word  = '1;
    tm_load  = 1'b0;
    tm_val   = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          erase_d  = erase_req;
          want_d   = erase_req ? '1 : ~target;
          wr_cnt_d = '0;
          pass_d   = 1'b0;
          verify_d = 1'b0;
          rd_idx_d = '0;
          sh_start = 1'b1;
          if (erase_req) begin
            sh_word = '1;
            state_d = ST_WR_SHIFT;
          end else begin
            sh_word = sel_low('0);
            state_d = ST_RD_SHIFT;
          end
        end
      end
      ST_RD_SHIFT: begin
        if (frame_done) begin
          tm_load = 1'b1;
          tm_val  = TW'(SETTLE_TK - 1);
          state_d = ST_RD_SETTLE;
        end
      end
      ST_RD_SETTLE: begin
        if (tm_exp) begin
          image_d[rd_idx_q] = sense_in;
          if (rd_idx_q == IW'(W - 1)) begin
            state_d = ST_EVAL;
          end else begin
            rd_idx_d = rd_idx_q + IW'(1);
            sh_start = 1'b1;
            sh_word  = sel_low(rd_idx_q + IW'(1));
            state_d  = ST_RD_SHIFT;
          end
        end
      end
      ST_EVAL: begin
        if (verify_q) begin
          pass_d  = (((image_q ^ want_q) & CHECK_MASK) == '0);
          state_d = ST_DONE;
        end else begin
          todo_d  = (image_q ^ want_q) & CHECK_MASK;
          state_d = ST_PICK;
        end
      end
      ST_PICK: begin
        sh_start = 1'b1;
        if (todo_q == '0) begin
          verify_d = 1'b1;
          rd_idx_d = '0;
          sh_word  = sel_low('0);
          state_d  = ST_RD_SHIFT;
        end else begin
          todo_d[pick_idx] = 1'b0;
          wr_cnt_d = wr_cnt_q + CW'(1);
          sh_word  = sel_low(pick_idx);
          state_d  = ST_WR_SHIFT;
        end
      end
      ST_WR_SHIFT: begin
        if (frame_done) begin
          tm_load = 1'b1;
          tm_val  = TW'(GAP_TK - 1);
          state_d = ST_WR_GAP1;
        end
      end
      ST_WR_GAP1: begin
        if (tm_exp) begin
          tm_load = 1'b1;
          tm_val  = TW'(PULSE_TK - 1);
          state_d = ST_WR_PULSE;
        end
      end
      ST_WR_PULSE: begin
        if (tm_exp) begin
          tm_load = 1'b1;
          tm_val  = TW'(GAP_TK - 1);
          state_d = ST_WR_GAP2;
        end
      end
      ST_WR_GAP2: begin
        if (tm_exp) begin
          if (erase_q) begin
            verify_d = 1'b1;
            rd_idx_d = '0;
            sh_start = 1'b1;
            sh_word  = sel_low('0);
            state_d  = ST_RD_SHIFT;
          end else begin
            state_d = ST_PICK;
          end
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      erase_q  <= 1'b0;
      verify_q <= 1'b0;
      rd_idx_q <= '0;
      image_q  <= '0;
      want_q   <= '0;
      todo_q   <= '0;
      wr_cnt_q <= '0;
      pass_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      erase_q  <= erase_d;
      verify_q <= verify_d;
      rd_idx_q <= rd_idx_d;
      image_q  <= image_d;
      want_q   <= want_d;
      todo_q   <= todo_d;
      wr_cnt_q <= wr_cnt_d;
      pass_q   <= pass_d;
    end
  end

  assign hold_high = (state_q == ST_RD_SETTLE);
  assign pv_en     = (state_q == ST_WR_PULSE);
  assign busy      = (state_q != ST_IDLE);
  assign done      = (state_q == ST_DONE);
  assign pass      = pass_q;
  assign wr_count  = wr_cnt_q;

endmodule

// File: rtl/trim_prog_seq.sv
module trim_prog_seq #(
  parameter int unsigned  W          = 11,
  parameter int unsigned  CLK_HZ     = 100000000,
  parameter int unsigned  SCLK_HZ    = 100000,
  parameter int unsigned  PULSE_US   = 10000,
  parameter int unsigned  GAP_US     = 4,
  parameter int unsigned  SETTLE_US  = 2,
  parameter logic [W-1:0] CHECK_MASK = {{(W-1){1'b1}}, 1'b0}
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   erase_req,
  input  logic [W-1:0]           target,
  input  logic                   sense_in,
  output logic                   ser_clk,
  output logic                   ser_data,
  output logic                   pv_en,
  output logic                   busy,
  output logic                   done,
  output logic                   pass,
  output logic [$clog2(W+1)-1:0] wr_count
);

  localparam int unsigned TICK_US   = CLK_HZ / 1000000;
  localparam int unsigned HALF_TK   = CLK_HZ / (2 * SCLK_HZ);
  localparam int unsigned PULSE_TK  = TICK_US * PULSE_US;
  localparam int unsigned GAP_TK    = TICK_US * GAP_US;
  localparam int unsigned SETTLE_TK = TICK_US * SETTLE_US;

  logic         sh_start, sh_clk, sh_data, frame_done, hold_high;
  logic [W-1:0] sh_word;

  trim_word_shifter #(
    .W       (W),
    .HALF_TK (HALF_TK)
  ) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (sh_start),
    .word_in    (sh_word),
    .ser_clk    (sh_clk),
    .ser_data   (sh_data),
    .frame_done (frame_done)
  );

  trim_prog_ctrl #(
    .W          (W),
    .CHECK_MASK (CHECK_MASK),
    .GAP_TK     (GAP_TK),
    .PULSE_TK   (PULSE_TK),
    .SETTLE_TK  (SETTLE_TK)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .erase_req  (erase_req),
    .target     (target),
    .sense_in   (sense_in),
    .frame_done (frame_done),
    .sh_start   (sh_start),
    .sh_word    (sh_word),
    .hold_high  (hold_high),
    .pv_en      (pv_en),
    .busy       (busy),
    .done       (done),
    .pass       (pass),
    .wr_count   (wr_count)
  );

  assign ser_clk  = sh_clk | hold_high;
  assign ser_data = sh_data | hold_high;

endmodule

// File: rtl/trim_prog_seq_chk.sv
module trim_prog_seq_chk #(
  parameter int unsigned GAP_TK   = 400,
  parameter int unsigned PULSE_TK = 1000000
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic ser_clk,
  input logic ser_data,
  input logic pv_en
);

  logic [31:0] low_run, since_pv, pulse_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run   <= '0;
      since_pv  <= GAP_TK;
      pulse_len <= '0;
    end else begin
      low_run   <= ser_clk ? '0 : ((low_run < GAP_TK) ? low_run + 1 : low_run);
      since_pv  <= pv_en ? '0 : ((since_pv < GAP_TK) ? since_pv + 1 : since_pv);
      pulse_len <= pv_en ? pulse_len + 1 : '0;
    end
  end

  assert_pulse_lines_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pv_en |-> (!ser_clk && !ser_data));

  assert_gap_before_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pv_en) |-> (low_run >= GAP_TK));

  assert_gap_after_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_clk) |-> (since_pv >= GAP_TK));

  assert_pulse_length_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pv_en) |-> (pulse_len == PULSE_TK));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_ends_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  assert_busy_needs_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

endmodule

bind trim_prog_seq trim_prog_seq_chk #(
  .GAP_TK   (GAP_TK),
  .PULSE_TK (PULSE_TK)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .ser_clk  (ser_clk),
  .ser_data (ser_data),
  .pv_en    (pv_en)
);

// File: tb/trim_prog_seq_bench.sv
module trim_prog_seq_bench;

  localparam int unsigned W         = 11;
  localparam int unsigned CLK_HZ    = 2000000;
  localparam int unsigned SCLK_HZ   = 100000;
  localparam int unsigned PULSE_US  = 100;
  localparam int unsigned GAP_US    = 4;
  localparam int unsigned SETTLE_US = 2;
  localparam int unsigned HALF_TK   = CLK_HZ / (2 * SCLK_HZ);
  localparam int unsigned PULSE_TK  = (CLK_HZ / 1000000) * PULSE_US;
  localparam int unsigned SETTLE_TK = (CLK_HZ / 1000000) * SETTLE_US;
  localparam logic [W-1:0] MASK     = 11'b111_1111_1110;
  localparam logic [W-1:0] ERASED   = 11'b111_1111_1110;

  typedef struct {
    bit           is_res;
    logic [W-1:0] word;
    bit           pass;
    int           cnt;
    string        req;
  } exp_item_t;

  logic         clk;
  logic         rst_n;
  logic         start;
  logic         erase_req;
  logic [W-1:0] target;
  logic         sense_in;
  logic         ser_clk, ser_data, pv_en, busy, done, pass;
  logic [3:0]   wr_count;

  logic [W-1:0] dev_mem;
  logic [W-1:0] shreg;
  exp_item_t    exp_q[$];
  int           checks;
  int           errors;

  trim_prog_seq #(
    .W         (W),
    .CLK_HZ    (CLK_HZ),
    .SCLK_HZ   (SCLK_HZ),
    .PULSE_US  (PULSE_US),
    .GAP_US    (GAP_US),
    .SETTLE_US (SETTLE_US)
  ) u_trim_prog_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .erase_req (erase_req),
    .target    (target),
    .sense_in  (sense_in),
    .ser_clk   (ser_clk),
    .ser_data  (ser_data),
    .pv_en     (pv_en),
    .busy      (busy),
    .done      (done),
    .pass      (pass),
    .wr_count  (wr_count)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int zero_pos(input logic [W-1:0] v);
    int n = 0;
    int p = -1;
    for (int i = 0; i < W; i++) begin
      if (!v[i]) begin
        n++;
        p = i;
      end
    end
    return (n == 1) ? p : -1;
  endfunction

  // device model: shift on rising serial clock, bit0 ends at index 0
  always @(posedge ser_clk) shreg <= {ser_data, shreg[W-1:1]};

  always_comb begin
    int z;
    z = zero_pos(shreg);
    sense_in = (ser_clk && ser_data && z >= 0) ? dev_mem[z] : 1'b0;
  end

  always @(posedge pv_en) begin
    int z;
    z = zero_pos(shreg);
    if (&shreg) dev_mem = ERASED;
    else if (z >= 0) dev_mem[z] = 1'b0;
  end

  task automatic check_val(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, expv);
    end
  endtask

  // monitor: pulse words and pulse length
  always @(posedge pv_en) begin
    exp_item_t it;
    int n;
    #1;
    if (exp_q.size() == 0 || exp_q[0].is_res) begin
      check_val("R9 unexpected pulse word", int'(shreg), -1);
    end else begin
      it = exp_q.pop_front();
      check_val(it.req, int'(shreg), int'(it.word));
    end
    n = 0;
    @(negedge clk);
    while (pv_en) begin
      n++;
      @(negedge clk);
    end
    check_val("R6 pulse length", n, PULSE_TK);
  end

  // monitor: end-of-sequence results
  always @(negedge clk) begin
    exp_item_t it;
    if (rst_n && done) begin
      if (exp_q.size() == 0 || !exp_q[0].is_res) begin
        check_val("R8 unexpected done", 1, 0);
      end else begin
        it = exp_q.pop_front();
        check_val({it.req, " pass"}, int'(pass), int'(it.pass));
        check_val({it.req, " wr_count"}, int'(wr_count), it.cnt);
      end
    end
  end

  // driver: predicts expected items from the requirements, then runs the op
  task automatic run_op(input bit er, input logic [W-1:0] tgt, input bit poke,
                        input string req);
    logic [W-1:0] m;
    logic [W-1:0] want;
    logic [W-1:0] diff;
    exp_item_t    it;
    int           cnt = 0;
    m    = dev_mem;
    want = er ? '1 : ~tgt;
    if (er) begin
      it = '{is_res: 0, word: '1, pass: 0, cnt: 0, req: {req, " R7 erase word"}};
      exp_q.push_back(it);
      m = ERASED;
    end else begin
      diff = (m ^ want) & MASK;
      for (int i = 0; i < W; i++) begin
        if (diff[i]) begin
          it = '{is_res: 0, word: ~(11'b1 << i), pass: 0, cnt: 0,
                 req: {req, " R5 write word"}};
          exp_q.push_back(it);
          m[i] = 1'b0;
          cnt++;
        end
      end
    end
    it = '{is_res: 1, word: '0, pass: (((m ^ want) & MASK) == '0), cnt: cnt,
           req: {req, " R8 result"}};
    exp_q.push_back(it);

    @(negedge clk);
    start     = 1'b1;
    erase_req = er;
    target    = tgt;
    @(negedge clk);
    start     = 1'b0;
    erase_req = 1'b0;
    if (poke) begin
      repeat (300) @(negedge clk);
      start     = 1'b1;
      erase_req = 1'b1;
      target    = ~tgt;
      @(negedge clk);
      start     = 1'b0;
      erase_req = 1'b0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    check_val({req, " R8 all items seen"}, exp_q.size(), 0);
    check_val({req, " R8 busy low after done"}, int'(busy), 0);
  endtask

  task automatic watch_first_frame();
    time t0, t1;
    @(posedge ser_clk);
    t0 = $time;
    #1 check_val("R2 bit0 first (select low)", int'(ser_data), 0);
    @(posedge ser_clk);
    t1 = $time;
    #1 check_val("R2 second bit high", int'(ser_data), 1);
    check_val("R2 serial period ticks", int'((t1 - t0) / 10), 2 * HALF_TK);
    repeat (W - 2) @(posedge ser_clk);
    repeat (HALF_TK + 2) @(negedge clk);
    check_val("R3 hold clk high", int'(ser_clk), 1);
    check_val("R3 hold data high", int'(ser_data), 1);
    repeat (SETTLE_TK - 1) @(negedge clk);
    check_val("R3 clk drops after sample", int'(ser_clk), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks    = 0;
    errors    = 0;
    rst_n     = 1'b0;
    start     = 1'b0;
    erase_req = 1'b0;
    target    = '0;
    dev_mem   = ERASED;
    shreg     = '0;
    repeat (3) @(negedge clk);
    check_val("R1 ser_clk in reset", int'(ser_clk), 0);
    check_val("R1 pv_en in reset", int'(pv_en), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_val("R1 ser_data after reset", int'(ser_data), 0);
    check_val("R1 busy after reset", int'(busy), 0);
    check_val("R1 done after reset", int'(done), 0);
    check_val("R1 pass after reset", int'(pass), 0);
    check_val("R1 wr_count after reset", int'(wr_count), 0);

    // R10 example target on erased device, with a start poke while busy (R9)
    fork
      watch_first_frame();
      run_op(1'b0, 11'b000_0001_0100, 1'b1, "R10 R9 example");
    join
    // same target again: no writes, check cell difference ignored (R4)
    run_op(1'b0, 11'b000_0001_0100, 1'b0, "R4 repeat");
    // target needing cells raised: verify must fail
    run_op(1'b0, 11'b001_0000_0000, 1'b0, "R8 fail");
    // erase restores cells
    run_op(1'b1, 11'b000_0000_0000, 1'b0, "R7 erase");
    check_val("R7 cells after erase", int'(dev_mem), int'(ERASED));
    // full target: ten writes in ascending order
    run_op(1'b0, 11'b111_1111_1111, 1'b0, "R5 full");
    check_val("R5 cells after full", int'(dev_mem), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule